// File: doc/BRIEF.md
# Sized Load/Store Byte-Lane Unit

This block connects a 32-bit register datapath to a data memory that is 32 bits wide and addressed in bytes. When a store arrives, it turns the effective address, the access size and the register value into three things: a word-aligned memory address, one write enable per byte lane, and write data moved onto the lanes that the address selects. When a load arrives, it records which lanes the request wants. On the next cycle, when the synchronous memory returns its word, it moves the selected byte or halfword down to the low end of the result and fills the upper bits with zeros or with copies of the sign bit.

The memory word is little-endian: the byte at the lowest address sits in bits 7:0. An access must start at an address that is a multiple of its size. When it does not, the block raises a fault flag in the request cycle, drives no write enables and returns zero as load data. Address arithmetic, the register file and bus handshakes belong to the surrounding pipeline.

Top module: `lsu_lane_steer`

## Requirements
- R1: `mem_addr` always equals `req_addr` with bits 1:0 forced to zero.
- R2: `req_fault` is high in a cycle exactly when `req_valid` is high and the access is misaligned. The size codes are 0 byte, 1 halfword, 2 or 3 word. Word needs address bits 1:0 = 00, halfword needs bit 0 = 0, and a byte is never misaligned.
- R3: A faulting request drives `mem_be` = 0000.
- R4: An aligned byte store drives the low byte of `req_wdata` onto all four lanes. It drives `mem_be` = 1 << addr[1:0].
- R5: An aligned halfword store drives the low halfword onto both halves. It drives `mem_be` = 0011 when addr[1] = 0 and 1100 when addr[1] = 1.
- R6: An aligned word store drives `mem_be` = 1111 and passes `req_wdata` unchanged. `req_signed` has no effect on any store.
- R7: `mem_be` is 0000 whenever no store is requested (`req_valid` low or `req_write` low).
- R8: `ld_valid` is high exactly one cycle after a load request (`req_valid` high, `req_write` low), whether or not that load faulted. `ld_data` is zero whenever `ld_valid` is low.
- R9: A word load returns `mem_rdata` unchanged, so bytes aa, bb, cc, dd at A..A+3 read back as 0xddccbbaa. `req_signed` has no effect on it.
- R10: A byte load returns lane addr[1:0] of `mem_rdata`. It is zero-extended when `req_signed` = 0 and sign-extended from bit 7 when `req_signed` = 1.
- R11: A halfword load returns half addr[1] of `mem_rdata`. It is zero-extended when `req_signed` = 0 and sign-extended from bit 15 when `req_signed` = 1.
- R12: The cycle that answers a misaligned load has `ld_valid` high and `ld_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_signed | input | 1 | Sign-extend byte/halfword loads |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Register data for stores |
| mem_rdata | input | 32 | Memory word, one cycle after the load request |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-steered store data |
| req_fault | output | 1 | Misaligned request this cycle |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Extracted, extended load result |

## Verification
A load answer and a new request share the same cycle: while the load issued in cycle N is extracted from `mem_rdata` in cycle N+1, the request in N+1 may be a store, a faulting store or another load. The bench issues requests back to back, including a halfword load followed at once by a misaligned word store. Its reference model keeps the pending load apart from the current request and checks, in every cycle, both the returned data and the fault flag and enables of the new request.

// File: rtl/lsu_pkg.sv
// Package: shared access-size encoding for the byte-lane unit.
// Assumes a two-bit size field; both upper codes mean a full word.
package lsu_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD3 = 2'd3
    } size_e;
endpackage

// File: rtl/lsu_align_chk.sv
// Alignment checker: flags a request whose address is not a multiple of its size.
// Assumes the offset input holds the in-word address bits.
module lsu_align_chk
    import lsu_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  size_e            size,
    input  logic [OFS_W-1:0] ofs,
    output logic             fault
);
    // Decide misalignment from size and the low address bits.
    always_comb begin
        case (size)
            SZ_BYTE: fault = 1'b0;
            SZ_HALF: fault = valid && ofs[0];
            default: fault = valid && (|ofs);
        endcase
    end

    assert_byte_never_faults_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (size == SZ_BYTE) |-> !fault);
    assert_idle_never_faults_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> !fault);
endmodule

// File: rtl/lsu_store_steer.sv
// Store steering: builds per-lane write enables and replicated write data.
// Assumes DATA_W is a multiple of 16 and the fault input comes from the alignment checker.
module lsu_store_steer
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              write,
    input  logic              fault,
    input  size_e             size,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata_out
);
    typedef logic [LANES-1:0] lane_t;

    // Replicate the stored byte or halfword across the lanes.
    always_comb begin
        case (size)
            SZ_BYTE: wdata_out = {LANES{wdata[7:0]}};
            SZ_HALF: wdata_out = {(LANES/2){wdata[15:0]}};
            default: wdata_out = wdata;
        endcase
    end

    // Select the enabled lanes, blocked for loads, idle cycles and faults.
    always_comb begin
        be = '0;
        case (size)
            SZ_BYTE: be[ofs] = 1'b1;
            SZ_HALF: be = lane_t'(3) << {ofs[OFS_W-1:1], 1'b0};
            default: be = '1;
        endcase
        if (!(valid && write) || fault) begin
            be = '0;
        end
    end

    assert_fault_blocks_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (be == '0));
    assert_byte_single_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && write && size == SZ_BYTE) |-> ($countones(be) == 1));
    assert_no_store_no_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && write) |-> (be == '0));
endmodule

// File: rtl/lsu_load_extract.sv
// Load extraction: picks the addressed byte/halfword from the returned word and extends it.
// Assumes its control inputs are the registered attributes of the load issued one cycle earlier.
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic              fault,
    input  size_e             size,
    input  logic              sgn,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] data
);
    logic [7:0]        byte_sel;
    logic [15:0]       half_sel;
    logic [DATA_W-1:0] ext;

    // Pick the addressed byte lane and the addressed halfword.
    always_comb begin
        byte_sel = '0;
        half_sel = '0;
        for (int i = 0; i < LANES; i++) begin
            if (ofs == i[OFS_W-1:0]) byte_sel = rdata[i*8 +: 8];
        end
        for (int j = 0; j < LANES / 2; j++) begin
            if (ofs[OFS_W-1:1] == j[OFS_W-2:0]) half_sel = rdata[j*16 +: 16];
        end
    end

    // Extend to the full width and zero the result for faults and idle cycles.
    always_comb begin
        case (size)
            SZ_BYTE: ext = {{(DATA_W-8){sgn & byte_sel[7]}}, byte_sel};
            SZ_HALF: ext = {{(DATA_W-16){sgn & half_sel[15]}}, half_sel};
            default: ext = rdata;
        endcase
        data = (valid && !fault) ? ext : '0;
    end

    assert_unsigned_byte_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !fault && size == SZ_BYTE && !sgn) |-> (data[DATA_W-1:8] == '0));
    assert_unsigned_half_upper_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !fault && size == SZ_HALF && !sgn) |-> (data[DATA_W-1:16] == '0));
    assert_word_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !fault && (size == SZ_WORD || size == SZ_WORD3)) |-> (data == rdata));
endmodule

// File: rtl/lsu_lane_steer.sv
// Top: sized load/store lane unit between a register datapath and a byte-lane memory.
// Assumes a synchronous-read memory returning data one cycle after the load request.
module lsu_lane_steer
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              req_fault,
    output logic              ld_valid,
    output logic [DATA_W-1:0] ld_data
);
    size_e            cur_size;
    logic [OFS_W-1:0] cur_ofs;
    logic             pend_valid;
    logic             pend_fault;
    size_e            pend_size;
    logic             pend_signed;
    logic [OFS_W-1:0] pend_ofs;

    assign cur_size = size_e'(req_size);
    assign cur_ofs  = req_addr[OFS_W-1:0];
    assign mem_addr = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    assign ld_valid = pend_valid;

    lsu_align_chk #(.OFS_W(OFS_W)) u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (req_valid),
        .size  (cur_size),
        .ofs   (cur_ofs),
        .fault (req_fault)
    );

    lsu_store_steer #(.DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (req_valid),
        .write     (req_write),
        .fault     (req_fault),
        .size      (cur_size),
        .ofs       (cur_ofs),
        .wdata     (req_wdata),
        .be        (mem_be),
        .wdata_out (mem_wdata)
    );

    // Hold the attributes of a load for the cycle its memory word returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid  <= 1'b0;
            pend_fault  <= 1'b0;
            pend_size   <= SZ_BYTE;
            pend_signed <= 1'b0;
            pend_ofs    <= '0;
        end else begin
            pend_valid  <= req_valid && !req_write;
            pend_fault  <= req_fault;
            pend_size   <= cur_size;
            pend_signed <= req_signed;
            pend_ofs    <= cur_ofs;
        end
    end

    lsu_load_extract #(.DATA_W(DATA_W)) u_load (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (pend_valid),
        .fault (pend_fault),
        .size  (pend_size),
        .sgn   (pend_signed),
        .ofs   (pend_ofs),
        .rdata (mem_rdata),
        .data  (ld_data)
    );

    assert_word_address_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr[OFS_W-1:0] == '0) && (mem_addr[ADDR_W-1:OFS_W] == req_addr[ADDR_W-1:OFS_W]));
    assert_load_answer_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(req_valid && !req_write));
    assert_idle_result_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> (ld_data == '0));
    assert_faulted_load_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && $past(req_fault)) |-> (ld_data == '0));
endmodule

// File: tb/sim_lsu_lane_steer.sv
`timescale 1ns/1ps
module sim_lsu_lane_steer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_signed;
    logic [1:0]  req_size;
    logic [31:0] req_addr, req_wdata, mem_rdata;
    logic [31:0] mem_addr, mem_wdata, ld_data;
    logic [3:0]  mem_be;
    logic        req_fault, ld_valid;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // Reference state of the load awaiting its memory word.
    bit        pv = 0, pf = 0, psg = 0;
    bit [1:0]  psz = 0;
    bit [31:0] pa = 0;

    always #2 clk = ~clk;

    lsu_lane_steer u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
        .req_wdata(req_wdata), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .req_fault(req_fault),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic bit [31:0] ref_load(bit [31:0] w, bit [1:0] sz, bit sg, bit [31:0] a);
        bit [31:0] r;
        if (sz == 0) begin
            r = (w >> (8 * a[1:0])) & 32'hff;
            if (sg && r[7]) r = r | 32'hffffff00;
        end else if (sz == 1) begin
            r = (w >> (16 * a[1])) & 32'hffff;
            if (sg && r[15]) r = r | 32'hffff0000;
        end else begin
            r = w;
        end
        return r;
    endfunction

    // One request cycle; rd is the memory word answering the previous cycle's load.
    task automatic step(input bit v, input bit w, input bit [1:0] sz, input bit sg,
                        input bit [31:0] a, input bit [31:0] wd, input bit [31:0] rd);
        bit        ef;
        bit [3:0]  ebe;
        bit [31:0] ewd;
        @(negedge clk);
        req_valid = v; req_write = w; req_size = sz; req_signed = sg;
        req_addr = a; req_wdata = wd; mem_rdata = rd;
        #1;
        ef = v && ((sz == 1 && a[0]) || (sz >= 2 && a[1:0] != 0));
        ebe = 4'h0;
        if (v && w && !ef) ebe = (sz == 0) ? (4'h1 << a[1:0]) : (sz == 1) ? (a[1] ? 4'hc : 4'h3) : 4'hf;
        ewd = (sz == 0) ? {4{wd[7:0]}} : (sz == 1) ? {2{wd[15:0]}} : wd;
        chk("R1 mem_addr", mem_addr, a & 32'hfffffffc);
        chk("R2 req_fault", {31'b0, req_fault}, {31'b0, ef});
        chk(ef ? "R3 mem_be" : (v && w) ? "R4/R5/R6 mem_be" : "R7 mem_be", {28'b0, mem_be}, {28'b0, ebe});
        if (ebe != 0) chk("R4/R5/R6 mem_wdata", mem_wdata, ewd);
        chk("R8 ld_valid", {31'b0, ld_valid}, {31'b0, pv});
        chk(!pv ? "R8 ld_data idle" : pf ? "R12 ld_data" : psz == 0 ? "R10 ld_data" :
            psz == 1 ? "R11 ld_data" : "R9 ld_data",
            ld_data, (pv && !pf) ? ref_load(rd, psz, psg, pa) : 32'h0);
        pv = v && !w; pf = ef; psz = sz; psg = sg; pa = a;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit [31:0] lf;
        rst_n = 0; req_valid = 0; req_write = 0; req_size = 0; req_signed = 0;
        req_addr = 0; req_wdata = 0; mem_rdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset ld_valid", {31'b0, ld_valid}, 32'h0);
        chk("R7 reset mem_be", {28'b0, mem_be}, 32'h0);
        rst_n = 1;
        // R6 word stores, aligned and misaligned (R3), signed flag ignored.
        step(1, 1, 2, 1, 32'h200, 32'hddccbbaa, 0);
        step(1, 1, 2, 0, 32'h202, 32'h12345678, 0);
        step(1, 1, 3, 0, 32'h201, 32'h12345678, 0);
        // R4 byte stores on every lane.
        for (int i = 0; i < 4; i++) step(1, 1, 0, i[0], 32'h300 + i, 32'h0000a5c3 + i, 0);
        // R5 halfword stores; odd address faults.
        step(1, 1, 1, 0, 32'h400, 32'h0000beef, 0);
        step(1, 1, 1, 1, 32'h402, 32'h0000cafe, 0);
        step(1, 1, 1, 0, 32'h403, 32'h0000cafe, 0);
        // R9 word load, answer next cycle.
        step(1, 0, 2, 1, 32'h200, 0, 0);
        step(0, 0, 0, 0, 0, 0, 32'hddccbbaa);
        // R10 byte loads, every lane, both extensions.
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 4; i++) begin
                step(1, 0, 0, s[0], 32'h500 + i, 0, 32'h0);
                step(0, 0, 0, 0, 0, 0, 32'h80ff7f01);
            end
        // R11 halfword loads, both halves, both extensions.
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 2; i++) begin
                step(1, 0, 1, s[0], 32'h600 + 2 * i, 0, 32'h0);
                step(0, 0, 0, 0, 0, 0, 32'h80017ffe);
            end
        // R12 misaligned loads return zero with ld_valid high.
        step(1, 0, 2, 0, 32'h702, 0, 0);
        step(1, 0, 1, 1, 32'h705, 0, 32'hffffffff);
        step(0, 0, 0, 0, 0, 0, 32'hffffffff);
        // Load answer in the same cycle as a faulting store (R3 with R11).
        step(1, 0, 1, 1, 32'h802, 0, 0);
        step(1, 1, 2, 0, 32'h801, 32'h11112222, 32'h9abc1234);
        step(1, 1, 0, 0, 32'h803, 32'h000000ee, 0);
        // Back-to-back mixed traffic from a fixed-seed shift register.
        lf = 32'h1ace5eed;
        for (int n = 0; n < 300; n++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step(lf[0], lf[1], lf[3:2], lf[4], {20'h0, lf[15:4]}, lf ^ 32'h5a5a0f0f, {lf[15:0], lf[31:16]});
        end
        step(0, 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule